// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the memory side of subroutine linkage for a processor in which register 1 is the stack pointer and register 0 is the frame pointer. A single start command selects one of three operations: a call to an absolute target, a call through a register, or a return. For each operation the block issues two 32-bit word accesses, one at a time, on a request/grant memory port with a separate read-response strobe. It then reports the new stack pointer, frame pointer and program counter, together with a one-cycle done pulse.

A call builds a three-word frame below the incoming stack pointer. The return address goes in the word at SP-8. The word at SP-4 is a static-chain slot that the block leaves untouched. The old frame pointer is stored at SP-12, and that address becomes both the new SP and the new FP. A return unwinds from the frame pointer, not from the stack pointer. It reloads FP from the word at FP and the PC from the word at FP+4, and leaves SP at FP+12. Instruction decode and the register file sit outside the block. The caller feeds in the register values and writes the results back.

Top module: `frame_seq`

## Requirements
- R1: After reset, done_o, err_o and mem_req_o are low and sp_o, fp_o and pc_o are zero.
- R2: kind_i selects the operation: 2'b00 is a call to an absolute target, 2'b01 is a call through a register, and 2'b10 or 2'b11 is a return. The first access of a call is a write at sp_i-8 of the return address, which is pc_i+6 for 2'b00 and pc_i+2 for 2'b01.
- R3: The second access of a call is a write at sp_i-12 of the value of fp_i.
- R4: In the cycle after the second call write is granted, done_o is high, sp_o and fp_o both equal sp_i-12, and pc_o equals target_i.
- R5: A return first reads the word at fp_i. Only after that read's response has arrived does it read the word at fp_i+4.
- R6: In the cycle after the second read response, done_o is high, fp_o equals the first read data, pc_o equals the second read data, and sp_o equals fp_i+12.
- R7: Once raised, mem_req_o, together with its address, write data and write flag, is held unchanged until mem_gnt_i. After a read is granted, mem_req_o stays low until mem_rvalid_i.
- R8: done_o lasts exactly one cycle. A start, and any change to the operand inputs, while an operation is in progress has no effect on the accesses or the results.
- R9: If the base of the operation (sp_i for a call, fp_i for a return) has bits [1:0] non-zero, err_o pulses high for one cycle in the cycle after the start. In that case there is no memory request, no done pulse, and sp_o, fp_o and pc_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, sampled while idle |
| kind_i | input | 2 | Operation: 00 absolute call, 01 register call, 1x return |
| pc_i | input | 32 | Address of the call instruction |
| target_i | input | 32 | Call destination |
| sp_i | input | 32 | Current stack pointer |
| fp_i | input | 32 | Current frame pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Operation complete, one cycle |
| err_o | output | 1 | Misaligned base rejected, one cycle |
| sp_o | output | 32 | Updated stack pointer |
| fp_o | output | 32 | Updated frame pointer |
| pc_o | output | 32 | Updated program counter |

## Verification
The hardest situation to reach from the ports is a memory port that stalls in the middle of a sequence while a fresh, different command arrives. Both the held-request rule and the ignore-while-busy rule depend on that overlap. The bench sweeps every operation kind against grant delays and read-response delays of zero to two cycles. In the cycle after each start, it raises start_i again with a different kind and shifted operands, and it checks the address of every stalled request each cycle. Misaligned bases are swept over all three non-zero low-bit patterns for both calls and returns.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_RA, ST_PUSH_FP, ST_RD_FP, ST_WT_FP, ST_RD_PC, ST_WT_PC
  } seq_st_e;

  function automatic logic kind_is_ret(input logic [1:0] kind);
    return kind[1];
  endfunction
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl import frame_seq_pkg::*; (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    is_ret_i,
  input  logic    misalign_i,
  input  logic    gnt_i,
  input  logic    rvalid_i,
  output seq_st_e st_o,
  output logic    accept_o,
  output logic    finish_o,
  output logic    req_o,
  output logic    we_o,
  output logic    done_o,
  output logic    err_o
);
  seq_st_e st_q, st_d;

  assign accept_o = (st_q == ST_IDLE) && start_i && !misalign_i;
  assign finish_o = ((st_q == ST_PUSH_FP) && gnt_i) || ((st_q == ST_WT_PC) && rvalid_i);
  assign req_o    = (st_q == ST_PUSH_RA) || (st_q == ST_PUSH_FP) ||
                    (st_q == ST_RD_FP) || (st_q == ST_RD_PC);
  assign we_o     = (st_q == ST_PUSH_RA) || (st_q == ST_PUSH_FP);
  assign st_o     = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (accept_o) st_d = is_ret_i ? ST_RD_FP : ST_PUSH_RA;
      ST_PUSH_RA: if (gnt_i) st_d = ST_PUSH_FP;
      ST_PUSH_FP: if (gnt_i) st_d = ST_IDLE;
      ST_RD_FP:   if (gnt_i) st_d = ST_WT_FP;
      ST_WT_FP:   if (rvalid_i) st_d = ST_RD_PC;
      ST_RD_PC:   if (gnt_i) st_d = ST_WT_PC;
      ST_WT_PC:   if (rvalid_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= finish_o;
      err_o  <= (st_q == ST_IDLE) && start_i && misalign_i;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!req_o && !done_o));
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (req_o && $stable(st_q)));
endmodule

// File: rtl/frame_dp.sv
module frame_dp import frame_seq_pkg::*; #(
  parameter int DW        = 32,
  parameter int LONG_LEN  = 6,
  parameter int SHORT_LEN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          finish_i,
  input  logic [1:0]    kind_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] target_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] fp_i,
  input  seq_st_e       st_i,
  input  logic          req_i,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] fp_o,
  output logic [DW-1:0] pc_o
);
  localparam int            LSB  = $clog2(DW / 8);
  localparam logic [DW-1:0] SLOT = DW'(DW / 8);

  logic [DW-1:0] base_q, ra_q, tgt_q, aux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ra_q   <= '0;
      tgt_q  <= '0;
      aux_q  <= '0;
      sp_o   <= '0;
      fp_o   <= '0;
      pc_o   <= '0;
    end else begin
      if (accept_i) begin
        base_q <= kind_is_ret(kind_i) ? fp_i : sp_i;
        ra_q   <= pc_i + (kind_i[0] ? DW'(SHORT_LEN) : DW'(LONG_LEN));
        tgt_q  <= target_i;
        aux_q  <= fp_i;
      end else if ((st_i == ST_WT_FP) && rvalid_i) begin
        aux_q  <= rdata_i;
      end
      if (finish_i) begin
        if (st_i == ST_PUSH_FP) begin
          sp_o <= base_q - 3 * SLOT;
          fp_o <= base_q - 3 * SLOT;
          pc_o <= tgt_q;
        end else begin
          sp_o <= base_q + 3 * SLOT;
          fp_o <= aux_q;
          pc_o <= rdata_i;
        end
      end
    end
  end

  // static-chain slot at base-SLOT is reserved, never touched
  always_comb begin
    addr_o  = base_q;
    wdata_o = '0;
    case (st_i)
      ST_PUSH_RA: begin addr_o = base_q - 2 * SLOT; wdata_o = ra_q;  end
      ST_PUSH_FP: begin addr_o = base_q - 3 * SLOT; wdata_o = aux_q; end
      ST_RD_PC:   addr_o = base_q + SLOT;
      default:    addr_o = base_q;
    endcase
  end

  assert_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !gnt_i) |=> ($stable(addr_o) && $stable(wdata_o)));
  assert_addr_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (addr_o[LSB-1:0] == '0));
endmodule

// File: rtl/frame_seq.sv
module frame_seq import frame_seq_pkg::*; #(
  parameter int DW        = 32,
  parameter int LONG_LEN  = 6,
  parameter int SHORT_LEN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    kind_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] target_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] fp_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] fp_o,
  output logic [DW-1:0] pc_o
);
  localparam int            LSB  = $clog2(DW / 8);
  localparam logic [DW-1:0] SLOT = DW'(DW / 8);

  seq_st_e       st;
  logic          accept, finish, is_ret, misalign;
  logic [DW-1:0] base_in;

  assign is_ret   = kind_is_ret(kind_i);
  assign base_in  = is_ret ? fp_i : sp_i;
  assign misalign = |base_in[LSB-1:0];

  frame_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .is_ret_i(is_ret),
    .misalign_i(misalign), .gnt_i(mem_gnt_i), .rvalid_i(mem_rvalid_i),
    .st_o(st), .accept_o(accept), .finish_o(finish), .req_o(mem_req_o),
    .we_o(mem_we_o), .done_o(done_o), .err_o(err_o)
  );

  frame_dp #(.DW(DW), .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .finish_i(finish),
    .kind_i(kind_i), .pc_i(pc_i), .target_i(target_i), .sp_i(sp_i), .fp_i(fp_i),
    .st_i(st), .req_i(mem_req_o), .gnt_i(mem_gnt_i), .rvalid_i(mem_rvalid_i),
    .rdata_i(mem_rdata_i), .addr_o(mem_addr_o), .wdata_o(mem_wdata_o),
    .sp_o(sp_o), .fp_o(fp_o), .pc_o(pc_o)
  );

  assert_call_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_ret) |=> (mem_req_o && mem_we_o && mem_addr_o == $past(sp_i) - 2 * SLOT));
  assert_ret_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_ret) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(fp_i)));
endmodule

// File: tb/frame_seq_tb.sv
`timescale 1ns/1ps
module frame_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [31:0] pc_i = '0, target_i = '0, sp_i = '0, fp_i = '0;
  logic        mem_req_o, mem_we_o, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic        done_o, err_o;
  logic [31:0] sp_o, fp_o, pc_o;
  int          checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  frame_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .kind_i(kind_i),
    .pc_i(pc_i), .target_i(target_i), .sp_i(sp_i), .fp_i(fp_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .err_o(err_o),
    .sp_o(sp_o), .fp_o(fp_o), .pc_o(pc_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input logic [1:0] k, input logic [31:0] pc, input logic [31:0] tgt,
                        input logic [31:0] sp, input logic [31:0] fp, input int gd, input int rd);
    logic        isr;
    logic [31:0] base, ld_fp, ld_pc, ea, ed;
    isr   = k[1];
    base  = isr ? fp : sp;
    ld_fp = fp ^ 32'h5A5A_0000;
    ld_pc = pc + 32'h0000_0100;
    @(negedge clk);
    start_i = 1'b1; kind_i = k; pc_i = pc; target_i = tgt; sp_i = sp; fp_i = fp;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      if (i == 0) begin
        // decoy command while busy
        kind_i = ~k; pc_i = pc + 32'h40; target_i = ~tgt; sp_i = sp + 32'h10; fp_i = fp + 32'h20;
      end else begin
        start_i = 1'b0;
      end
      if (!isr) begin
        ea = (i == 0) ? base - 32'd8 : base - 32'd12;
        ed = (i == 0) ? pc + ((k == 2'b00) ? 32'd6 : 32'd2) : fp;
        chk(mem_req_o && mem_we_o, (i == 0) ? "R2 call write req" : "R3 call write req",
            {30'd0, mem_req_o, mem_we_o}, 32'd3);
        chk(mem_addr_o == ea, (i == 0) ? "R2 call addr" : "R3 call addr", mem_addr_o, ea);
        chk(mem_wdata_o == ed, (i == 0) ? "R2 return address data" : "R3 old fp data", mem_wdata_o, ed);
      end else begin
        ea = (i == 0) ? base : base + 32'd4;
        chk(mem_req_o && !mem_we_o, "R5 return read req", {30'd0, mem_req_o, mem_we_o}, 32'd2);
        chk(mem_addr_o == ea, "R5 return read addr", mem_addr_o, ea);
      end
      for (int w = 0; w < gd; w++) begin
        @(negedge clk);
        start_i = 1'b0;
        chk(mem_req_o && mem_addr_o == ea, "R7 request held until grant", mem_addr_o, ea);
      end
      mem_gnt_i = 1'b1;
      @(negedge clk);
      mem_gnt_i = 1'b0; start_i = 1'b0;
      if (isr) begin
        for (int w = 0; w < rd; w++) begin
          chk(!mem_req_o, "R7 no request while read outstanding", {31'd0, mem_req_o}, 32'd0);
          @(negedge clk);
        end
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = (i == 0) ? ld_fp : ld_pc;
        @(negedge clk);
        mem_rvalid_i = 1'b0; mem_rdata_i = 32'hDEAD_BEEF;
      end
    end
    chk(done_o, isr ? "R6 done after second response" : "R4 done after second write",
        {31'd0, done_o}, 32'd1);
    if (!isr) begin
      chk(sp_o == sp - 32'd12, "R4 sp result", sp_o, sp - 32'd12);
      chk(fp_o == sp - 32'd12, "R4 fp result", fp_o, sp - 32'd12);
      chk(pc_o == tgt, "R4 pc result", pc_o, tgt);
    end else begin
      chk(sp_o == fp + 32'd12, "R6 sp result", sp_o, fp + 32'd12);
      chk(fp_o == ld_fp, "R6 fp result", fp_o, ld_fp);
      chk(pc_o == ld_pc, "R6 pc result", pc_o, ld_pc);
    end
    chk(!mem_req_o, "R8 no extra access from decoy start", {31'd0, mem_req_o}, 32'd0);
    @(negedge clk);
    chk(!done_o, "R8 done single cycle", {31'd0, done_o}, 32'd0);
    chk(!mem_req_o, "R8 idle after done", {31'd0, mem_req_o}, 32'd0);
  endtask

  task automatic run_bad(input logic [1:0] k, input logic [31:0] sp, input logic [31:0] fp);
    logic [31:0] psp, pfp, ppc;
    psp = sp_o; pfp = fp_o; ppc = pc_o;
    @(negedge clk);
    start_i = 1'b1; kind_i = k; sp_i = sp; fp_i = fp; pc_i = 32'h10; target_i = 32'h20;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o, "R9 err pulse", {31'd0, err_o}, 32'd1);
    chk(!mem_req_o && !done_o, "R9 no access no done", {30'd0, mem_req_o, done_o}, 32'd0);
    @(negedge clk);
    chk(!err_o, "R9 err single cycle", {31'd0, err_o}, 32'd0);
    chk(!mem_req_o, "R9 still no access", {31'd0, mem_req_o}, 32'd0);
    chk(sp_o == psp && fp_o == pfp && pc_o == ppc, "R9 results unchanged", sp_o, psp);
  endtask

  initial begin
    logic [31:0] bases [4];
    bases[0] = 32'h0000_1000; bases[1] = 32'h0000_2004;
    bases[2] = 32'h0000_0008; bases[3] = 32'hFFFF_FFF4;
    #1;
    chk(!done_o && !err_o && !mem_req_o, "R1 reset flags", {29'd0, done_o, err_o, mem_req_o}, 32'd0);
    chk(sp_o == 0 && fp_o == 0 && pc_o == 0, "R1 reset results", sp_o | fp_o | pc_o, 32'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++)
      for (int g = 0; g < 3; g++)
        for (int r = 0; r < 3; r++)
          for (int b = 0; b < 4; b++)
            run_op(2'(k), 32'h0000_8000 + 32'(b * 6 + g), 32'h0004_0000 + 32'(k * 16 + r),
                   bases[b], bases[b] ^ 32'h0000_0100, g, r);
    for (int k = 0; k < 3; k++)
      for (int lo = 1; lo < 4; lo++)
        if (k < 2) run_bad(2'(k), 32'h0000_1000 + 32'(lo), 32'h0000_2000);
        else       run_bad(2'b10, 32'h0000_1000, 32'h0000_2000 + 32'(lo));
    run_op(2'b01, 32'h0000_0400, 32'h0000_0800, 32'h0000_3000, 32'h0000_3100, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule